// File: doc/BRIEF.md
# Serial EEPROM Boot Fetcher

This block is a two-wire serial master that runs once after reset. It copies a boot image out of a serial EEPROM. A single start pulse launches a fixed bus sequence, and no processor takes part. In the default mode, the sequence first loads the EEPROM's internal address pointer with zero. It does this by sending the device address for writing, followed by a one-byte word address, and no data byte. Without a STOP, it then begins a second transfer that addresses the device for reading. It then pulls in the requested number of bytes as one continuous sequential read. The master acknowledges every byte except the last, which gets a not-acknowledge and a STOP. In the alternative mode, the pointer phase is skipped. The read then starts wherever the EEPROM's pointer already sits.

Each received byte appears on a byte output with a one-cycle valid strobe. A one-cycle done pulse marks a clean finish. A missing slave acknowledge on any address phase ends the transfer with a STOP and raises a sticky error flag. The bus lines are open-drain style: the block only drives low or releases, and it reads back the data line. The bit rate comes from a parameterised divider of the system clock.

Top module: `i2c_boot_reader`

## Requirements
- R1: After reset, both bus drive-low enables are 0 (lines released), and data_valid_o, done_o and error_o are 0. Nothing changes on the bus until start_i is pulsed.
- R2: With mode_cur_i = 0, the bus carries the following, in order: START; the byte 0xA0 (the address 1010000 followed by a 0 direction bit), MSB first; the slave acknowledge slot; the word address byte 0x00; the slave acknowledge slot. Then, with no STOP in between, a second START and the byte 0xA1 (the direction bit is 1).
- R3: The block receives bytes MSB first. Each one is presented on data_o with data_valid_o high for exactly one clock. Exactly N bytes are delivered, in EEPROM address order.
- R4: The master drives an acknowledge (data line low) after each of the first N-1 bytes. It releases the line (not-acknowledge) after byte N, then sends exactly one STOP, after which both lines are released.
- R5: With mode_cur_i = 1, the sequence is a single START, the byte 0xA1, the slave acknowledge, then the read of R3/R4. The bytes start at the pointer already held by the EEPROM.
- R6: A byte count of 0 on count_i is treated as 1. The count is captured at the start pulse.
- R7: If any address phase sees no slave acknowledge (the data line reads high), the block sends a STOP and sets error_o. error_o stays high until reset. No byte is delivered, done_o never pulses, and no retry START follows.
- R8: On success, done_o pulses high for exactly one clock after the STOP, with error_o low.
- R9: Every SCL high phase lasts exactly 2*DIV clocks. The two lines never change in the same clock. The data line changes while SCL is high only to form the expected START and STOP conditions.
- R10: start_i is ignored while a transfer runs and after it has finished. The block fetches only once per reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that launches the fetch |
| mode_cur_i | input | 1 | 0: set the pointer to 0 first; 1: read from the current pointer |
| count_i | input | CNT_W | Number of bytes to fetch (0 is taken as 1) |
| sda_i | input | 1 | Sampled level of the serial data line |
| scl_oe_o | output | 1 | Pull the serial clock line low when 1 |
| sda_oe_o | output | 1 | Pull the serial data line low when 1 |
| data_o | output | 8 | Last received byte |
| data_valid_o | output | 1 | One-cycle strobe for data_o |
| done_o | output | 1 | One-cycle pulse after a successful STOP |
| error_o | output | 1 | Sticky flag: an address phase was not acknowledged |

## Verification
A wrong sequencer state shows up at the ports within one bus symbol. It appears as an extra or missing START or STOP, as a wrong address byte decoded by the bench's EEPROM model, or as an acknowledge where a not-acknowledge belongs. A slipped bit counter or byte counter shifts every following byte, so the first delivered byte already disagrees with the arithmetic memory pattern. A miscounted byte total changes the number of strobes and the master-acknowledge tally before done. Faults in the quarter-phase engine appear directly as an SCL high time other than 2*DIV clocks, or as both lines moving in the same cycle.

// File: rtl/i2c_boot_pkg.sv
package i2c_boot_pkg;

    typedef enum logic [1:0] {
        SYM_START,
        SYM_STOP,
        SYM_WR,
        SYM_RD
    } sym_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_DEVW,
        S_ACKW,
        S_WORD,
        S_ACKA,
        S_RSTART,
        S_DEVR,
        S_ACKR,
        S_READ,
        S_MACK,
        S_STOP,
        S_FIN
    } seq_e;

endpackage

// File: rtl/boot_tick_gen.sv
module boot_tick_gen #(
    parameter int DIV = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = en_i && (cnt_q == CW'(DIV - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)       cnt_d = '0;
        else if (tick_o) cnt_d = '0;
        else if (en_i)   cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/boot_sym_engine.sv
// Plays one bus symbol in four quarter phases; outputs are registered levels.
module boot_sym_engine
    import i2c_boot_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic go_i,
    input  sym_e sym_i,
    input  logic wbit_i,
    input  logic sda_i,
    output logic busy_o,
    output logic fin_o,
    output logic rbit_o,
    output logic scl_low_o,
    output logic sda_low_o
);
    typedef struct packed {
        logic       busy;
        logic [1:0] ph;
        sym_e       sym;
        logic       wbit;
        logic       scl_low;
        logic       sda_low;
        logic       rbit;
        logic       fin;
    } eng_t;

    eng_t st_d, st_q;

    // {scl_low, sda_low} for a symbol in a given quarter
    function automatic logic [1:0] lvl(input sym_e s, input logic [1:0] p, input logic wb);
        logic [1:0] r;
        case (s)
            SYM_START: case (p)
                2'd0:    r = 2'b10;
                2'd1:    r = 2'b00;
                2'd2:    r = 2'b01;
                default: r = 2'b11;
            endcase
            SYM_STOP: case (p)
                2'd0:    r = 2'b11;
                2'd1:    r = 2'b01;
                default: r = 2'b00;
            endcase
            SYM_WR:  r = {(p == 2'd0) || (p == 2'd3), !wb};
            default: r = {(p == 2'd0) || (p == 2'd3), 1'b0};
        endcase
        return r;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        if (go_i && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.ph   = 2'd0;
            st_d.sym  = sym_i;
            st_d.wbit = wbit_i;
            {st_d.scl_low, st_d.sda_low} = lvl(sym_i, 2'd0, wbit_i);
        end else if (st_q.busy && tick_i) begin
            if (st_q.ph == 2'd3) begin
                st_d.busy = 1'b0;
                st_d.fin  = 1'b1;
            end else begin
                st_d.ph = st_q.ph + 2'd1;
                {st_d.scl_low, st_d.sda_low} = lvl(st_q.sym, st_q.ph + 2'd1, st_q.wbit);
                if (st_q.ph == 2'd1) st_d.rbit = sda_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{busy: 1'b0, ph: 2'd0, sym: SYM_STOP, wbit: 1'b1,
                               scl_low: 1'b0, sda_low: 1'b0, rbit: 1'b1, fin: 1'b0};
        else         st_q <= st_d;
    end

    assign busy_o    = st_q.busy;
    assign fin_o     = st_q.fin;
    assign rbit_o    = st_q.rbit;
    assign scl_low_o = st_q.scl_low;
    assign sda_low_o = st_q.sda_low;
endmodule

// File: rtl/i2c_boot_reader.sv
module i2c_boot_reader
    import i2c_boot_pkg::*;
#(
    parameter int         DIV       = 8,
    parameter int         CNT_W     = 16,
    parameter logic [6:0] DEV_ADDR  = 7'b1010000,
    parameter logic [7:0] WORD_ADDR = 8'h00
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             mode_cur_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic [7:0]       data_o,
    output logic             data_valid_o,
    output logic             done_o,
    output logic             error_o
);
    localparam logic [7:0] DEV_W = {DEV_ADDR, 1'b0};
    localparam logic [7:0] DEV_R = {DEV_ADDR, 1'b1};

    typedef struct packed {
        seq_e             st;
        logic             issue;
        logic [2:0]       bitn;
        logic [7:0]       shreg;
        logic [CNT_W-1:0] remain;
        logic             cur;
        logic             fail;
        logic             err;
        logic [7:0]       data;
        logic             valid;
        logic             done;
    } ctl_t;

    ctl_t c_d, c_q;

    logic tick, eng_busy, eng_fin, eng_rbit, scl_low, sda_low;
    sym_e sym;
    logic wbit;

    always_comb begin
        case (c_q.st)
            S_START, S_RSTART:               sym = SYM_START;
            S_STOP:                          sym = SYM_STOP;
            S_ACKW, S_ACKA, S_ACKR, S_READ:  sym = SYM_RD;
            default:                         sym = SYM_WR;
        endcase
        case (c_q.st)
            S_DEVW:  wbit = DEV_W[3'd7 - c_q.bitn];
            S_WORD:  wbit = WORD_ADDR[3'd7 - c_q.bitn];
            S_DEVR:  wbit = DEV_R[3'd7 - c_q.bitn];
            S_MACK:  wbit = (c_q.remain == CNT_W'(1));
            default: wbit = 1'b1;
        endcase
    end

    always_comb begin
        c_d       = c_q;
        c_d.issue = 1'b0;
        c_d.valid = 1'b0;
        c_d.done  = 1'b0;
        if (c_q.st == S_IDLE) begin
            if (start_i) begin
                c_d.st     = S_START;
                c_d.issue  = 1'b1;
                c_d.remain = (count_i == '0) ? CNT_W'(1) : count_i;
                c_d.cur    = mode_cur_i;
            end
        end else if (eng_fin) begin
            c_d.issue = 1'b1;
            case (c_q.st)
                S_START: begin
                    c_d.bitn = 3'd0;
                    c_d.st   = c_q.cur ? S_DEVR : S_DEVW;
                end
                S_DEVW, S_WORD, S_DEVR: begin
                    c_d.bitn = c_q.bitn + 3'd1;
                    if (c_q.bitn == 3'd7)
                        c_d.st = (c_q.st == S_DEVW) ? S_ACKW :
                                 (c_q.st == S_WORD) ? S_ACKA : S_ACKR;
                end
                S_ACKW, S_ACKA, S_ACKR: begin
                    c_d.bitn = 3'd0;
                    if (eng_rbit) begin
                        c_d.fail = 1'b1;
                        c_d.st   = S_STOP;
                    end else begin
                        c_d.st = (c_q.st == S_ACKW) ? S_WORD :
                                 (c_q.st == S_ACKA) ? S_RSTART : S_READ;
                    end
                end
                S_RSTART: begin
                    c_d.bitn = 3'd0;
                    c_d.st   = S_DEVR;
                end
                S_READ: begin
                    c_d.shreg = {c_q.shreg[6:0], eng_rbit};
                    c_d.bitn  = c_q.bitn + 3'd1;
                    if (c_q.bitn == 3'd7) begin
                        c_d.data  = {c_q.shreg[6:0], eng_rbit};
                        c_d.valid = 1'b1;
                        c_d.st    = S_MACK;
                    end
                end
                S_MACK: begin
                    c_d.bitn = 3'd0;
                    if (c_q.remain == CNT_W'(1)) begin
                        c_d.st = S_STOP;
                    end else begin
                        c_d.remain = c_q.remain - CNT_W'(1);
                        c_d.st     = S_READ;
                    end
                end
                S_STOP: begin
                    c_d.issue = 1'b0;
                    c_d.st    = S_FIN;
                    if (c_q.fail) c_d.err  = 1'b1;
                    else          c_d.done = 1'b1;
                end
                default: c_d.issue = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '{st: S_IDLE, issue: 1'b0, bitn: 3'd0, shreg: 8'h00,
                              remain: '0, cur: 1'b0, fail: 1'b0, err: 1'b0,
                              data: 8'h00, valid: 1'b0, done: 1'b0};
        else         c_q <= c_d;
    end

    boot_tick_gen #(.DIV(DIV)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (c_q.issue),
        .en_i   (eng_busy),
        .tick_o (tick)
    );

    boot_sym_engine u_eng (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .go_i      (c_q.issue),
        .sym_i     (sym),
        .wbit_i    (wbit),
        .sda_i     (sda_i),
        .busy_o    (eng_busy),
        .fin_o     (eng_fin),
        .rbit_o    (eng_rbit),
        .scl_low_o (scl_low),
        .sda_low_o (sda_low)
    );

    assign scl_oe_o     = scl_low;
    assign sda_oe_o     = sda_low;
    assign data_o       = c_q.data;
    assign data_valid_o = c_q.valid;
    assign done_o       = c_q.done;
    assign error_o      = c_q.err;
endmodule

// File: rtl/boot_reader_chk.sv
module boot_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic valid,
    input logic done,
    input logic error
);
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    a_r7_no_done_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !done);

    a_r4_released_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!scl_oe && !sda_oe));

    a_r9_one_line_moves: assert property (@(posedge clk) disable iff (!rst_n)
        !(!$stable(scl_oe) && !$stable(sda_oe)));
endmodule

bind i2c_boot_reader boot_reader_chk u_chk (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .scl_oe (scl_oe_o),
    .sda_oe (sda_oe_o),
    .valid  (data_valid_o),
    .done   (done_o),
    .error  (error_o)
);

// File: tb/i2c_boot_reader_bench.sv
module i2c_boot_reader_bench;
    localparam int DIV   = 2;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode_cur = 1'b0;
    logic [CNT_W-1:0] count = '0;
    logic scl_oe, sda_oe, valid, done, error;
    logic [7:0] data;
    logic slv_low = 1'b0;
    logic sda_w, scl_w;

    assign scl_w = ~scl_oe;
    assign sda_w = ~(sda_oe | slv_low);

    always #2 clk = ~clk;

    i2c_boot_reader #(.DIV(DIV), .CNT_W(CNT_W)) u_i2c_boot_reader (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .start_i      (start),
        .mode_cur_i   (mode_cur),
        .count_i      (count),
        .sda_i        (sda_w),
        .scl_oe_o     (scl_oe),
        .sda_oe_o     (sda_oe),
        .data_o       (data),
        .data_valid_o (valid),
        .done_o       (done),
        .error_o      (error)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] memv(input logic [7:0] a);
        return (a * 8'd37) + 8'd91;
    endfunction

    // EEPROM model and monitors
    int ph, bitcnt, sbit, starts, stops, addr_n, macks, mnacks, nrx, done_cnt;
    int hi_len, hi_min, hi_max;
    bit hi_active, ackd, mack_last, nack_dev, nack_word;
    logic [7:0] rx, txb, ptr, word_seen, exp_base;
    logic [7:0] addr_log [0:3];
    logic prev_scl = 1'b1, prev_sda = 1'b1;

    always @(negedge clk) begin
        cyc++;
        if (valid) begin
            chk(data == memv(exp_base + 8'(nrx)), "R3 byte value", int'(data),
                int'(memv(exp_base + 8'(nrx))));
            nrx++;
        end
        if (done) done_cnt++;
        if (scl_w && prev_scl && prev_sda && !sda_w) begin
            starts++; ph = 1; bitcnt = 0; rx = 8'h00; slv_low = 1'b0;
        end else if (scl_w && prev_scl && !prev_sda && sda_w) begin
            stops++; ph = 0; slv_low = 1'b0;
        end else if (scl_w && !prev_scl) begin
            if ((ph == 1 || ph == 2) && bitcnt < 8) begin
                rx = {rx[6:0], sda_w}; bitcnt++;
            end else if (ph == 4 && sbit == 9) begin
                mack_last = !sda_w;
                if (!sda_w) macks++; else mnacks++;
            end
        end else if (!scl_w && prev_scl) begin
            if ((ph == 1 || ph == 2) && bitcnt == 8) begin
                if (ph == 1) begin
                    if (addr_n < 4) addr_log[addr_n] = rx;
                    addr_n++;
                    ackd = (rx[7:1] == 7'b1010000) && !nack_dev;
                end else begin
                    ackd = !nack_word;
                end
                slv_low = ackd; bitcnt = 9;
            end else if ((ph == 1 || ph == 2) && bitcnt == 9) begin
                slv_low = 1'b0; bitcnt = 0;
                if (!ackd) ph = 0;
                else if (ph == 1) begin
                    if (rx[0]) begin
                        ph = 4; txb = memv(ptr); slv_low = !txb[7]; sbit = 1;
                    end else ph = 2;
                end else begin
                    word_seen = rx; ptr = rx; ph = 3;
                end
            end else if (ph == 4) begin
                if (sbit < 8) begin
                    slv_low = !txb[7-sbit]; sbit++;
                end else if (sbit == 8) begin
                    slv_low = 1'b0; sbit = 9;
                end else begin
                    ptr = ptr + 8'd1;
                    if (mack_last) begin
                        txb = memv(ptr); slv_low = !txb[7]; sbit = 1;
                    end else ph = 5;
                end
            end
        end
        if (scl_w && !prev_scl) begin
            hi_active = 1'b1; hi_len = 1;
        end else if (scl_w && hi_active) begin
            hi_len++;
        end else if (!scl_w && prev_scl && hi_active) begin
            if (hi_len < hi_min) hi_min = hi_len;
            if (hi_len > hi_max) hi_max = hi_len;
            hi_active = 1'b0;
        end
        prev_scl = scl_w;
        prev_sda = sda_w;
    end

    task automatic pulse_start(input bit cur, input int cnt);
        mode_cur = cur;
        count = CNT_W'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input bit cur, input int cnt, input logic [7:0] p0,
                       input bit ndev, input bit nword, input bit retrig);
        int n_eff, guard;
        bit exp_err;
        rst_n = 1'b0;
        @(negedge clk);
        ph = 0; bitcnt = 0; sbit = 0; starts = 0; stops = 0; addr_n = 0;
        macks = 0; mnacks = 0; nrx = 0; done_cnt = 0; hi_active = 1'b0;
        hi_min = 1000000; hi_max = 0; slv_low = 1'b0; ptr = p0;
        word_seen = 8'hEE; nack_dev = ndev; nack_word = nword;
        exp_base = cur ? p0 : 8'h00;
        n_eff = (cnt == 0) ? 1 : cnt;
        exp_err = ndev || (nword && !cur);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        // R1: idle state before start
        chk(!scl_oe && !sda_oe && !valid && !done && !error, "R1 idle outputs",
            int'({scl_oe, sda_oe, valid, done, error}), 0);
        chk(starts == 0, "R1 no bus activity before start", starts, 0);
        pulse_start(cur, cnt);
        if (retrig) begin
            repeat (30) @(negedge clk);
            pulse_start(cur, cnt);
        end
        guard = 0;
        while (done_cnt == 0 && !error && guard < 30000) begin
            @(negedge clk);
            guard++;
        end
        repeat (10) @(negedge clk);
        if (exp_err) begin
            chk(error == 1'b1, "R7 error flag", int'(error), 1);
            chk(done_cnt == 0, "R7 no done", done_cnt, 0);
            chk(nrx == 0, "R7 no data", nrx, 0);
            chk(stops == 1 && starts == 1, "R7 single start and stop",
                starts * 10 + stops, 11);
        end else begin
            chk(error == 1'b0, "R8 error low", int'(error), 0);
            chk(done_cnt == 1, "R8 one done cycle", done_cnt, 1);
            chk(nrx == n_eff, cnt == 0 ? "R6 zero count gives one byte" : "R3 byte count",
                nrx, n_eff);
            chk(macks == n_eff - 1, "R4 master acks", macks, n_eff - 1);
            chk(mnacks == 1, "R4 final noack", mnacks, 1);
            chk(stops == 1, "R4 one stop", stops, 1);
            chk(!scl_oe && !sda_oe, "R4 lines released", int'({scl_oe, sda_oe}), 0);
            chk(hi_min == 2 * DIV && hi_max == 2 * DIV, "R9 scl high time",
                hi_min * 1000 + hi_max, 2 * DIV * 1001);
            if (cur) begin
                chk(starts == 1, "R5 single start", starts, 1);
                chk(addr_n == 1 && addr_log[0] == 8'hA1, "R5 read address",
                    int'(addr_log[0]), 8'hA1);
            end else begin
                chk(starts == 2, "R2 repeated start", starts, 2);
                chk(addr_n == 2 && addr_log[0] == 8'hA0 && addr_log[1] == 8'hA1,
                    "R2 address bytes", int'({addr_log[0], addr_log[1]}), 16'hA0A1);
                chk(word_seen == 8'h00, "R2 word address", int'(word_seen), 0);
            end
        end
        if (retrig) begin
            pulse_start(cur, cnt);
            repeat (300) @(negedge clk);
            chk(starts == (cur ? 1 : 2), "R10 start ignored after finish", starts,
                cur ? 1 : 2);
            chk(nrx == n_eff, "R10 no extra bytes", nrx, n_eff);
        end
    endtask

    initial begin
        for (int n = 1; n <= 12; n++) run(1'b0, n, 8'h77, 1'b0, 1'b0, 1'b0);
        for (int n = 1; n <= 5; n++)  run(1'b1, n, 8'h3C + 8'(n), 1'b0, 1'b0, 1'b0);
        run(1'b1, 4, 8'hFE, 1'b0, 1'b0, 1'b0);
        run(1'b0, 0, 8'h10, 1'b0, 1'b0, 1'b0);
        run(1'b0, 3, 8'h10, 1'b0, 1'b0, 1'b1);
        run(1'b1, 2, 8'h20, 1'b0, 1'b0, 1'b1);
        run(1'b0, 4, 8'h00, 1'b1, 1'b0, 1'b0);
        run(1'b0, 4, 8'h00, 1'b0, 1'b1, 1'b0);
        run(1'b1, 4, 8'h00, 1'b1, 1'b0, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        while (cyc < 190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule